// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller

This block turns single-word host requests into strobe sequences for an asynchronous, byte-wide DRAM whose address pins carry half of the cell address at a time. Each host address is split in two. The upper half is the row and is latched by the falling edge of the active-low row strobe. The lower half is the column and is latched by the falling edge of the active-low column strobe on the same pins. A byte-wide data path is formed by eight single-bit arrays that share every address. The controller drives the write-enable or output-enable strobe for the whole byte.

After an access the row stays open. A later request to the same row goes straight to the column phase. A request to a different row first closes the open row and waits out the precharge time. A read request can ask for a burst, which returns four words from one row (the addressed column and the three after it, wrapping inside the row) with no further row transfer.

A free-running timer raises a refresh demand at a fixed interval. The controller services it between accesses. It closes any open row and then runs a row-strobe-only cycle on a refresh row counter that advances by one each time.

Top module: `dramc_top`

## Requirements
- R1: After reset the row, column, write and output strobes are all high (inactive), the host ready output is high, read-valid is low, and no row is treated as open.
- R2: Host address bits [AW-1:AW/2] are on the DRAM address pins when the row strobe falls. Bits [AW/2-1:0] are on the pins when the column strobe falls.
- R3: A write holds the write strobe low and drives the write byte on DQ while the column strobe is low. A read holds the output strobe low with the write strobe high. The byte read is returned with a one-cycle read-valid pulse. The write and output strobes are never low together.
- R4: The column strobe falls no sooner than T_RCD cycles after the row strobe fell. It stays low for at least T_CAS cycles, and only while the row strobe is low.
- R5: A request to the row that is already open causes no new row-strobe fall.
- R6: Before any row-strobe fall, the row strobe has been high for at least T_RP cycles.
- R7: A read with the burst flag set returns four read-valid pulses. These carry the words at columns c, c+1, c+2 and c+3 modulo the row length, in that order, with at most one row-strobe fall. The column strobe goes high for one cycle between beats.
- R8: On a write, the burst flag has no effect: exactly one column-strobe fall occurs, and neighbouring words are unchanged.
- R9: The host ready output is low while an access or refresh sequence runs. A request is taken only in a cycle where both valid and ready are high.
- R10: A refresh is a row-strobe cycle with no column-strobe fall. Refresh rows follow 0, 1, 2 and so on, modulo the row count. The first refresh starts REF_PERIOD cycles after reset plus at most one access. Later refreshes start no more than REF_PERIOD plus one access apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can take a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_burst_i | input | 1 | Four-word burst (reads only) |
| req_addr_i | input | AW | Cell address, row in the upper half |
| req_wdata_i | input | DW | Write data |
| rd_valid_o | output | 1 | One-cycle pulse per returned word |
| rd_data_o | output | DW | Returned word |
| dram_addr_o | output | AW/2 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write strobe, active low |
| dram_oe_no | output | 1 | Output strobe, active low |
| dram_dq_o | output | DW | Write data to DRAM |
| dram_dq_oe_o | output | 1 | DQ driven by controller |
| dram_dq_i | input | DW | Read data from DRAM |

## Verification
If the open-row tag or open flag held a wrong value, a hit would go to the column phase against a stale row. The very next read would return a byte from the wrong row, and the bench model's row-strobe count would disagree at once. A wrong phase counter shows up as a strobe-spacing violation on the first access, which the bench's behavioural DRAM measures cycle by cycle. A refresh row register that skips or sticks is caught at the next refresh, which is at most REF_PERIOD plus one access later. A burst column that fails to wrap returns a wrong word on the third or fourth pulse.

// File: rtl/dramc_pkg.sv
package dramc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_ACT, ST_CAS, ST_GAP, ST_REF, ST_RFP
  } dramc_st_e;
endpackage

// File: rtl/dramc_ref_timer.sv
module dramc_ref_timer #(
  parameter int REF_PERIOD = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic req_o
);
  localparam int CW = $clog2(REF_PERIOD);
  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick = (cnt_q == CW'(REF_PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_o <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)       req_o <= 1'b1;
      else if (ack_i) req_o <= 1'b0;
    end
  end

  a_r10_ack_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> req_o);
endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
  import dramc_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RP  = 3,
  parameter int T_RFS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ref_req_i,
  output logic          ref_ack_o,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic          req_burst_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic [AW/2-1:0] dram_addr_o,
  output logic          dram_ras_no,
  output logic          dram_cas_no,
  output logic          dram_we_no,
  output logic          dram_oe_no,
  output logic [DW-1:0] dram_dq_o,
  output logic          dram_dq_oe_o,
  input  logic [DW-1:0] dram_dq_i
);
  localparam int HW   = AW / 2;
  localparam int TM1  = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int TM2  = (T_RP > T_RFS) ? T_RP : T_RFS;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW   = $clog2(TMAX + 1);

  dramc_st_e     st_q, st_n;
  logic [CW-1:0] cnt_q;
  logic          row_open_q, ref_op_q, we_q;
  logic [HW-1:0] open_row_q, row_q, col_q, ref_row_q;
  logic [DW-1:0] wdata_q;
  logic [1:0]    beats_q;
  logic          accept, hit, last;

  function automatic logic [CW-1:0] dur(dramc_st_e s);
    case (s)
      ST_PRE, ST_RFP: dur = CW'(T_RP);
      ST_ACT:         dur = CW'(T_RCD);
      ST_CAS:         dur = CW'(T_CAS);
      ST_REF:         dur = CW'(T_RFS);
      default:        dur = CW'(1);
    endcase
  endfunction

  assign req_ready_o = (st_q == ST_IDLE) && !ref_req_i;
  assign accept      = req_valid_i && req_ready_o;
  assign hit         = row_open_q && (req_addr_i[AW-1:HW] == open_row_q);
  assign last        = (cnt_q == '0);

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_IDLE: if (ref_req_i)   st_n = row_open_q ? ST_PRE : ST_REF;
               else if (accept) st_n = hit ? ST_CAS : (row_open_q ? ST_PRE : ST_ACT);
      ST_PRE:  if (last) st_n = ref_op_q ? ST_REF : ST_ACT;
      ST_ACT:  if (last) st_n = ST_CAS;
      ST_CAS:  if (last) st_n = (beats_q != '0) ? ST_GAP : ST_IDLE;
      ST_GAP:  st_n = ST_CAS;
      ST_REF:  if (last) st_n = ST_RFP;
      ST_RFP:  if (last) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  assign ref_ack_o = (st_n == ST_REF) && (st_q != ST_REF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      row_open_q <= 1'b0;
      open_row_q <= '0;
      ref_op_q   <= 1'b0;
      we_q       <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      wdata_q    <= '0;
      beats_q    <= '0;
      ref_row_q  <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      st_q       <= st_n;
      rd_valid_o <= 1'b0;
      if (st_n != st_q)   cnt_q <= dur(st_n) - 1'b1;
      else if (!last)     cnt_q <= cnt_q - 1'b1;
      if (st_q == ST_IDLE && ref_req_i) ref_op_q <= 1'b1;
      if (accept) begin
        ref_op_q <= 1'b0;
        we_q     <= req_we_i;
        row_q    <= req_addr_i[AW-1:HW];
        col_q    <= req_addr_i[HW-1:0];
        wdata_q  <= req_wdata_i;
        beats_q  <= (req_burst_i && !req_we_i) ? 2'd3 : 2'd0;
      end
      if (st_q == ST_ACT) begin
        row_open_q <= 1'b1;
        open_row_q <= row_q;
      end
      if (st_n == ST_PRE || st_n == ST_REF) row_open_q <= 1'b0;
      if (st_q == ST_CAS && last) begin
        if (!we_q) begin
          rd_valid_o <= 1'b1;
          rd_data_o  <= dram_dq_i;
        end
        if (beats_q != '0) begin
          beats_q <= beats_q - 1'b1;
          col_q   <= col_q + 1'b1; // wraps inside the row
        end
      end
      if (st_q == ST_REF && last) ref_row_q <= ref_row_q + 1'b1;
    end
  end

  assign dram_ras_no  = !((st_q == ST_ACT) || (st_q == ST_CAS) || (st_q == ST_GAP) ||
                          (st_q == ST_REF) || (st_q == ST_IDLE && row_open_q));
  assign dram_cas_no  = !(st_q == ST_CAS);
  assign dram_we_no   = !(st_q == ST_CAS && we_q);
  assign dram_oe_no   = !(st_q == ST_CAS && !we_q);
  assign dram_dq_o    = wdata_q;
  assign dram_dq_oe_o = (st_q == ST_CAS) && we_q;
  assign dram_addr_o  = (st_q == ST_CAS || st_q == ST_GAP) ? col_q :
                        (st_q == ST_REF) ? ref_row_q : row_q;

  // strobe width trackers for the checks below
  logic [CW:0] cas_w_q, ras_w_q, rh_w_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cas_w_q <= '0;
      ras_w_q <= '0;
      rh_w_q  <= (CW+1)'(TMAX);
    end else begin
      cas_w_q <= dram_cas_no ? '0 : cas_w_q + 1'b1;
      ras_w_q <= dram_ras_no ? '0 : ((ras_w_q >= (CW+1)'(TMAX)) ? ras_w_q : ras_w_q + 1'b1);
      rh_w_q  <= !dram_ras_no ? '0 : ((rh_w_q >= (CW+1)'(TMAX)) ? rh_w_q : rh_w_q + 1'b1);
    end
  end

  a_r4_cas_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dram_cas_no) |-> cas_w_q >= (CW+1)'(T_CAS));
  a_r4_ras_to_cas: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_cas_no) |-> ras_w_q >= (CW+1)'(T_RCD));
  a_r4_cas_inside_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dram_cas_no |-> !dram_ras_no);
  a_r6_precharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> rh_w_q >= (CW+1)'(T_RP));
  a_r3_we_oe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dram_we_no && !dram_oe_no));
  a_r9_no_cas_when_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> dram_cas_no);
endmodule

// File: rtl/dramc_top.sv
module dramc_top #(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 2,
  parameter int T_RP       = 3,
  parameter int T_RFS      = 4,
  parameter int REF_PERIOD = 256
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_we_i,
  input  logic            req_burst_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [DW-1:0]   req_wdata_i,
  output logic            rd_valid_o,
  output logic [DW-1:0]   rd_data_o,
  output logic [AW/2-1:0] dram_addr_o,
  output logic            dram_ras_no,
  output logic            dram_cas_no,
  output logic            dram_we_no,
  output logic            dram_oe_no,
  output logic [DW-1:0]   dram_dq_o,
  output logic            dram_dq_oe_o,
  input  logic [DW-1:0]   dram_dq_i
);
  logic ref_req, ref_ack;

  dramc_ref_timer #(.REF_PERIOD(REF_PERIOD)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ref_ack), .req_o(ref_req)
  );

  dramc_seq #(
    .AW(AW), .DW(DW), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_RFS(T_RFS)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .ref_req_i(ref_req), .ref_ack_o(ref_ack),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_we_i(req_we_i), .req_burst_i(req_burst_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .dram_addr_o(dram_addr_o), .dram_ras_no(dram_ras_no), .dram_cas_no(dram_cas_no),
    .dram_we_no(dram_we_no), .dram_oe_no(dram_oe_no),
    .dram_dq_o(dram_dq_o), .dram_dq_oe_o(dram_dq_oe_o), .dram_dq_i(dram_dq_i)
  );
endmodule

// File: tb/tb_dramc_top.sv
`timescale 1ns/1ps
module tb_dramc_top;
  localparam int AW = 8, DW = 8, HW = AW/2;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, T_RFS = 4, REF_PERIOD = 256;
  localparam int SLACK = 40;
  localparam int NCELL = 1 << AW, NROW = 1 << HW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_burst = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DW-1:0] rd_data, dq_o, dq_i;
  logic [HW-1:0] daddr;

  always #2 clk = ~clk;

  dramc_top #(.AW(AW), .DW(DW), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP),
              .T_RFS(T_RFS), .REF_PERIOD(REF_PERIOD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_burst_i(req_burst), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .dram_addr_o(daddr), .dram_ras_no(ras_n), .dram_cas_no(cas_n),
    .dram_we_no(we_n), .dram_oe_no(oe_n), .dram_dq_o(dq_o),
    .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural DRAM model and strobe monitor
  logic [DW-1:0] mem [NCELL];
  logic [DW-1:0] shadow [NCELL];
  logic [HW-1:0] m_row = '0, last_row = '0, last_col = '0;
  int rl = 0, rh = 1000, cl = 0, cyc = 0;
  bit p_ras = 1, p_cas = 1, had_cas = 0;
  int n_act = 0, n_casf = 0, n_ref = 0, exp_ref_row = 0;
  int ras_fall_cyc = 0, last_ref_cyc = 0;
  logic [DW-1:0] rq [$];

  assign dq_i = mem[{m_row, daddr}];

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (!ras_n && p_ras) begin
        chk(rh >= T_RP, "R6 precharge", rh, T_RP);
        m_row = daddr; rl = 1; had_cas = 0; ras_fall_cyc = cyc;
      end else if (!ras_n) rl++;
      if (ras_n) rh = p_ras ? rh + 1 : 1;
      if (!cas_n && p_cas) begin
        chk(!ras_n, "R4 cas inside ras", ras_n, 0);
        chk(rl - 1 >= T_RCD, "R4 ras-to-cas", rl - 1, T_RCD);
        had_cas = 1; n_casf++; last_row = m_row; last_col = daddr; cl = 1;
        if (rl - 1 == T_RCD) n_act++;
      end else if (!cas_n) cl++;
      if (cas_n && !p_cas) chk(cl >= T_CAS, "R4 cas width", cl, T_CAS);
      if (!cas_n && !we_n) begin
        chk(dq_oe, "R3 dq driven on write", dq_oe, 1);
        mem[{m_row, daddr}] = dq_o;
      end
      if (!we_n && !oe_n) chk(0, "R3 we/oe overlap", 1, 0);
      if (ras_n && !p_ras && !had_cas) begin
        chk(int'(m_row) == exp_ref_row, "R10 refresh row", m_row, exp_ref_row);
        exp_ref_row = (exp_ref_row + 1) % NROW;
        if (n_ref == 0)
          chk(ras_fall_cyc >= REF_PERIOD && ras_fall_cyc <= REF_PERIOD + SLACK,
              "R10 first refresh time", ras_fall_cyc, REF_PERIOD);
        else
          chk(ras_fall_cyc - last_ref_cyc <= REF_PERIOD + SLACK,
              "R10 refresh interval", ras_fall_cyc - last_ref_cyc, REF_PERIOD);
        last_ref_cyc = ras_fall_cyc;
        n_ref++;
      end
      if (rd_valid) rq.push_back(rd_data);
      p_ras = ras_n; p_cas = cas_n;
    end
  end

  task automatic do_req(input bit we, input bit burst, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
    int w = 0;
    @(negedge clk);
    while (!req_ready && w < 200) begin @(negedge clk); w++; end
    req_valid = 1; req_we = we; req_burst = burst; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R9 ready low while busy", req_ready, 0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    do_req(1, 0, a, d);
    shadow[a] = d;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic rd_expect(input logic [AW-1:0] a, input bit burst, input string tag);
    int n = burst ? 4 : 1;
    rq.delete();
    do_req(0, burst, a, '0);
    for (int w = 0; w < 100 && rq.size() < n; w++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(rq.size() == n, {tag, " pulse count"}, rq.size(), n);
    for (int i = 0; i < n && i < rq.size(); i++) begin
      logic [AW-1:0] ea = {a[AW-1:HW], HW'(a[HW-1:0] + i)};
      chk(rq[i] == shadow[ea], {tag, " data"}, rq[i], shadow[ea]);
    end
  endtask

  task automatic wait_ref();
    int r0 = n_ref;
    for (int w = 0; w < 2 * REF_PERIOD && n_ref == r0; w++) @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes idle", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(req_ready, "R1 ready", req_ready, 1);
    chk(!rd_valid, "R1 rd_valid", rd_valid, 0);
  endtask

  task automatic t_write_read();
    wr(8'hA5, 8'h3C);
    chk(last_row == 4'hA, "R2 row half", last_row, 10);
    chk(last_col == 4'h5, "R2 col half", last_col, 5);
    wr(8'h5A, 8'hC3);
    rd_expect(8'hA5, 0, "R3 read A5");
    chk(last_row == 4'hA && last_col == 4'h5, "R2 read address", {last_row, last_col}, 8'hA5);
    rd_expect(8'h5A, 0, "R3 read 5A");
  endtask

  task automatic t_page();
    int a0;
    wait_ref();
    a0 = n_act;
    rd_expect(8'h51, 0, "R5 first");
    rd_expect(8'h57, 0, "R5 hit");
    wr(8'h5E, 8'h99);
    chk(n_act - a0 == 1, "R5 single activation", n_act - a0, 1);
    a0 = n_act;
    rd_expect(8'h92, 0, "R6 miss read");
    chk(n_act - a0 == 1, "R6 miss activation", n_act - a0, 1);
  endtask

  task automatic t_burst();
    int a0, c0;
    wr(8'h3E, 8'h11); wr(8'h3F, 8'h22); wr(8'h30, 8'h33); wr(8'h31, 8'h44);
    wait_ref();
    a0 = n_act; c0 = n_casf;
    rd_expect(8'h3E, 1, "R7 burst wrap");
    chk(n_act - a0 <= 1, "R7 activations", n_act - a0, 1);
    chk(n_casf - c0 == 4, "R7 column strobes", n_casf - c0, 4);
    rd_expect(8'hC4, 1, "R7 burst plain");
  endtask

  task automatic t_burst_write();
    int c0 = n_casf;
    do_req(1, 1, 8'h64, 8'h77);
    shadow[8'h64] = 8'h77;
    while (!req_ready) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_casf - c0 == 1, "R8 single write strobe", n_casf - c0, 1);
    rd_expect(8'h64, 1, "R8 neighbours unchanged");
  endtask

  task automatic t_refresh();
    int r0 = n_ref;
    repeat (3 * REF_PERIOD + SLACK) @(negedge clk);
    chk(n_ref - r0 >= 3, "R10 refresh count", n_ref - r0, 3);
  endtask

  initial begin
    for (int i = 0; i < NCELL; i++) begin
      mem[i] = DW'(i * 37 + 5);
      shadow[i] = DW'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write_read();
    t_page();
    t_burst();
    t_burst_write();
    t_refresh();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule